// File: doc/BRIEF.md
# I2C Master SCL Baud Generator

This block produces the serial clock for one byte transfer of an I2C master. A reloadable down counter sets the half period of SCL. Each time the counter runs out, SCL changes level, so one full SCL period takes two runs of the counter. A single write strobe starts a transfer and needs no separate enable. The block then gives nine SCL clocks: eight data bits and the acknowledge bit. After the ninth falling edge it stops and leaves SCL low.

The counter is paced by a cycle enable that fires once every `PRE_DIV` system clocks. The default `PRE_DIV` is 2, which gives an SCL frequency of Fsys / (4 × (reload + 1)). With a 16 MHz system clock, a reload of 9 gives 400 kHz and a reload of 39 gives 100 kHz. A reload of 0 gives the fastest rate.

While the block has SCL released high, it watches the sensed line. If a slave holds the line low, counting pauses until the line reads high again. SDA shifting, START/STOP conditions and arbitration are handled elsewhere.

Top module: `i2c_scl_baud`

## Requirements
- R1: After reset, `scl_o` is 1 (released), `busy` is 0 and `done` is 0.
- R2: A `wr_stb` that is sampled while `busy` is 0 sets `busy` to 1 and drives `scl_o` to 0 on that same clock edge.
- R3: While a transfer runs, `scl_o` changes level every 2 × (reload + 1) system clocks. One SCL period is therefore 4 × (reload + 1) clocks. The `reload` value is sampled at the start and at each level change.
- R4: A reload of 0 is legal. It makes `scl_o` change level every 2 system clocks.
- R5: A transfer has exactly nine rising edges on `scl_o`. `busy` falls on the edge that makes the ninth falling edge, and `scl_o` is 0 from then on.
- R6: `done` is high for exactly one system clock, on the same edge on which `busy` falls.
- R7: While `scl_o` is 1 and `scl_in` reads 0, the count is frozen. `scl_o` stays 1, and the transfer gets longer by exactly the number of clocks stalled.
- R8: A `wr_stb` sampled while `busy` is 1 is ignored. The length of the transfer and the SCL waveform do not change.
- R9: While idle, `scl_o` keeps the level it had when the last transfer ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | 8 | Counter reload value that sets the half period |
| wr_stb | input | 1 | Transmit buffer write strobe that starts a transfer |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_o | output | 1 | SCL drive level (1 = released, 0 = pulled low) |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-clock pulse when the transfer ends |

## Verification
The hardest case to reach is a slave holding SCL low just after the block releases it. In that case the stall has to stretch only the high phase, and the end of the transfer must move by exactly the stalled clocks. The bench models the line as a wired-AND of `scl_o` and its own stretch flag. It raises that flag right after it sees a rising edge of `scl_o` and holds it for a set number of clocks. A write strobe pulsed in the middle of that same transfer also covers the ignored-write case while counting is frozen nearby.

// File: rtl/i2c_scl_baud.sv
module i2c_scl_baud #(
  parameter int W       = 8,
  parameter int PRE_DIV = 2,
  parameter int NBITS   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  input  logic         wr_stb,
  input  logic         scl_in,
  output logic         scl_o,
  output logic         busy,
  output logic         done
);
  localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int FW = $clog2(NBITS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [FW-1:0] FALL_LAST = FW'(NBITS - 1);

  logic [PW-1:0] pre;
  logic [W-1:0]  cnt;
  logic [FW-1:0] falls;

  wire stall = scl_o & ~scl_in;
  wire tick  = busy & ~stall & (pre == PRE_LAST);
  wire roll  = tick & (cnt == '0);
  wire last  = roll & scl_o & (falls == FALL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt   <= '0;
      falls <= '0;
      scl_o <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (wr_stb) begin
          busy  <= 1'b1;
          scl_o <= 1'b0;
          pre   <= '0;
          cnt   <= reload;
          falls <= '0;
        end
      end else begin
        if (!stall) pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        if (tick) begin
          if (roll) begin
            cnt   <= reload;
            scl_o <= ~scl_o;
            if (scl_o) falls <= falls + 1'b1;
            if (last) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

module i2c_scl_baud_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic scl_in,
  input logic scl_o,
  input logic busy,
  input logic done
);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_stb) |=> (busy && !scl_o));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scl_o && !scl_in) |=> scl_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_stb) |=> $stable(scl_o));
  // R5
  end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_o);
endmodule

bind i2c_scl_baud i2c_scl_baud_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .scl_in(scl_in),
  .scl_o(scl_o), .busy(busy), .done(done)
);

// File: tb/test_i2c_scl_baud.sv
`timescale 1ns/1ps
module test_i2c_scl_baud;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] reload = 0;
  logic       wr_stb = 0;
  logic       stretch = 0;
  logic       scl_in;
  logic       scl_o, busy, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign scl_in = scl_o & ~stretch;

  i2c_scl_baud i_i2c_scl_baud (
    .clk(clk), .rst_n(rst_n), .reload(reload), .wr_stb(wr_stb),
    .scl_in(scl_in), .scl_o(scl_o), .busy(busy), .done(done)
  );

  // behavioural reference: remaining clocks until next level change
  bit m_scl = 1, m_busy = 0, m_done = 0;
  int m_rem = 0, m_falls = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scl = 1; m_busy = 0; m_done = 0; m_rem = 0; m_falls = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (wr_stb) begin
          m_busy = 1; m_scl = 0; m_falls = 0; m_rem = 2 * (int'(reload) + 1);
        end
      end else if (!(m_scl && stretch)) begin
        m_rem--;
        if (m_rem == 0) begin
          if (m_scl) begin
            m_falls++;
            if (m_falls == 9) begin m_busy = 0; m_done = 1; end
          end
          m_scl = !m_scl;
          m_rem = 2 * (int'(reload) + 1);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(scl_o == m_scl, "R3 scl_o vs model", scl_o, m_scl);
    chk(busy == m_busy, "R2 busy vs model", busy, m_busy);
    chk(done == m_done, "R6 done vs model", done, m_done);
  end

  task automatic run(input int r, input int s, input bit extra_wr);
    int cyc = 0, rises = 0;
    bit prev, stretched = 0;
    int hold = 0;
    @(negedge clk); reload = 8'(r); wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    chk(busy == 1 && scl_o == 0, "R2 start", {busy, scl_o}, 2);
    prev = scl_o;
    while (busy && cyc < 20000) begin
      cyc++;
      if (scl_o && !prev) rises++;
      prev = scl_o;
      if (hold > 0) begin hold--; if (hold == 0) stretch = 0; end
      else if (s > 0 && !stretched && scl_o && rises == 1) begin
        stretch = 1; hold = s; stretched = 1;
      end
      wr_stb = extra_wr && (cyc == 10);
      if (extra_wr && cyc == 10) reload = 8'(r + 5);
      if (extra_wr && cyc == 11) reload = 8'(r);
      @(negedge clk);
    end
    wr_stb = 0; stretch = 0;
    if (s > 0) chk(cyc == 36 * (r + 1) + s, "R7 stretched length", cyc, 36 * (r + 1) + s);
    else if (extra_wr) chk(cyc == 36 * (r + 1), "R8 length with ignored write", cyc, 36 * (r + 1));
    else if (r == 0) chk(cyc == 36, "R4 reload zero length", cyc, 36);
    else chk(cyc == 36 * (r + 1), "R3 transfer length", cyc, 36 * (r + 1));
    chk(rises == 9, "R5 rising edges", rises, 9);
    chk(done == 1 && scl_o == 0, "R6 done at end", {done, scl_o}, 2);
    @(negedge clk);
    chk(done == 0, "R6 done one clock", done, 0);
    repeat (6) @(negedge clk);
    chk(scl_o == 0 && busy == 0, "R9 idle holds low", {scl_o, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o == 1 && busy == 0 && done == 0, "R1 reset state", {scl_o, busy, done}, 4);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(scl_o == 1 && busy == 0, "R1 idle after reset", {scl_o, busy}, 2);
    run(0, 0, 0);
    run(3, 0, 0);
    run(9, 0, 0);
    run(2, 0, 1);
    run(4, 7, 0);
    run(1, 3, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule